// File: doc/BRIEF.md
# Host Channel Interrupt Aggregator

This block gathers the interrupt events raised by a bank of USB host channel engines and reduces them to a single level-sensitive interrupt line for the core. Each channel engine pulses event bits for one cycle. These bits cover USB-side conditions such as transfer done or channel halted, and system-bus-side conditions such as a bus error. Each channel has a status register that holds those events. It also has an enable mask that decides which held events may raise an interrupt.

The interrupt has three levels. A per-channel pending bit is the OR of that channel's enabled status bits. The summary register collects the twelve pending bits. A single core bit, which also drives the output line, is the OR of the summary. Software reads the core bit, reads the summary to find a channel that needs service, then reads and clears that channel's status. Software clears only at the channel level. The summary bit and the core bit follow without any further write.

Register map on the simple bus, one word per address. Reads are combinational from `regAddr`. A write takes effect at the clock edge while `regWrEn` is high. Address 0 is the core word, with the core bit at bit 0. Address 1 is the summary word, with channel `c` at bit `c`. Address `2+2c` is the status of channel `c`. Address `3+2c` is the mask of channel `c`. A mask bit of 1 lets the matching status bit through.

Top module: `hcirq_agg`

## Requirements
- R1: After reset every status and mask register reads zero, the summary and core words read zero, and `irqOut` is low.
- R2: An event pulse on bit `b` of channel `c` (`evtPulse[c*EVT_W+b]`) sets bit `b` of that channel's status register at the next clock edge, whatever the mask says.
- R3: Writing to a status address clears each status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Summary bit `c` (address 1) is 1 exactly when channel `c` has a status bit that is set and enabled in its mask.
- R6: The core word's bit 0 and `irqOut` are 1 exactly when some summary bit is 1. All other bits of the core word read 0.
- R7: A write to a mask address stores the low `EVT_W` data bits and reads back unchanged. Enabling a bit that is already pending raises the summary bit and `irqOut` in the cycle after the write.
- R8: Writes to address 0 or address 1 change no register.
- R9: `irqOut` stays high while any enabled pending event remains, and it falls only after the last such event is cleared.
- R10: A write to one channel's status or mask register does not alter any other register, including that channel's other register.
- R11: Addresses beyond the last mask register read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W (5) | Register word address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | DATA_W (16) | Write data: clear bits for status, new value for mask |
| regRdData | output | DATA_W (16) | Combinational read data of the addressed register |
| evtPulse | input | NUM_CHAN*EVT_W (96) | One-cycle event pulses, channel `c` at bits `c*EVT_W +: EVT_W` |
| irqOut | output | 1 | Level interrupt to the core |

## Verification
The collision that matters here is a channel engine raising an event in the same cycle that software writes a one to clear that very status bit. The bench forces this directly on a chosen channel and bit. It also lets it occur at random, since random writes and random event pulses share the same cycles. The result is judged by reading the status word back. The bit must stay set, and the summary and `irqOut` must still reflect it when it is enabled. A mask write that lands together with a new event on the same channel is treated the same way: the bench compares against a model that applies both in one step.

// File: rtl/hcirq_pkg.sv
package hcirq_pkg;

  typedef enum logic [2:0] {
    RD_NONE    = 3'd0,
    RD_CORE    = 3'd1,
    RD_SUMMARY = 3'd2,
    RD_STATUS  = 3'd3,
    RD_MASK    = 3'd4
  } rd_sel_e;

  // Strobes from decode to the register datapath
  typedef struct packed {
    logic       statusClr;
    logic       maskWr;
    rd_sel_e    rdSel;
    logic [7:0] chanIdx;
  } hcirq_strb_t;

endpackage

// File: rtl/hcirq_ctrl.sv
module hcirq_ctrl
  import hcirq_pkg::*;
#(
  parameter int NUM_CHAN = 12,
  parameter int ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output hcirq_strb_t       strb
);

  localparam int NUM_REGS = 2 + 2 * NUM_CHAN;

  logic [ADDR_W-1:0] chanOff;

  assign chanOff = regAddr - ADDR_W'(2);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    if (regAddr == ADDR_W'(0)) begin
      strb.rdSel = RD_CORE;          // upper levels are read-only
    end else if (regAddr == ADDR_W'(1)) begin
      strb.rdSel = RD_SUMMARY;
    end else if (32'(regAddr) < NUM_REGS) begin
      strb.chanIdx = 8'(chanOff >> 1);
      if (chanOff[0]) begin
        strb.rdSel  = RD_MASK;
        strb.maskWr = regWrEn;
      end else begin
        strb.rdSel     = RD_STATUS;
        strb.statusClr = regWrEn;
      end
    end
  end

endmodule

// File: rtl/hcirq_dp.sv
module hcirq_dp
  import hcirq_pkg::*;
#(
  parameter int NUM_CHAN = 12,
  parameter int EVT_W    = 8,
  parameter int DATA_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  hcirq_strb_t               strb,
  input  logic [EVT_W-1:0]          wrBits,
  input  logic [NUM_CHAN*EVT_W-1:0] evtPulse,
  output logic [DATA_W-1:0]         rdData,
  output logic                      coreIrq,
  output logic [NUM_CHAN*EVT_W-1:0] statusAll,
  output logic [NUM_CHAN*EVT_W-1:0] maskAll,
  output logic [NUM_CHAN-1:0]       summary
);

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic [EVT_W-1:0] statQ;
    logic [EVT_W-1:0] maskQ;
    logic             selHit;
    logic [EVT_W-1:0] clrBits;

    assign selHit  = (strb.chanIdx == 8'(ch));
    assign clrBits = (strb.statusClr && selHit) ? wrBits : '0;

    // Clear first, then OR new events so a colliding event survives
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ <= '0;
      end else begin
        statQ <= (statQ & ~clrBits) | evtPulse[ch*EVT_W +: EVT_W];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ <= '0;
      end else if (strb.maskWr && selHit) begin
        maskQ <= wrBits;
      end
    end

    assign summary[ch]                 = |(statQ & maskQ);
    assign statusAll[ch*EVT_W +: EVT_W] = statQ;
    assign maskAll[ch*EVT_W +: EVT_W]   = maskQ;
  end

  assign coreIrq = |summary;

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      RD_CORE:    rdData[0] = coreIrq;
      RD_SUMMARY: rdData[NUM_CHAN-1:0] = summary;
      RD_STATUS: begin
        for (int ch = 0; ch < NUM_CHAN; ch++) begin
          if (strb.chanIdx == 8'(ch)) rdData[EVT_W-1:0] = statusAll[ch*EVT_W +: EVT_W];
        end
      end
      RD_MASK: begin
        for (int ch = 0; ch < NUM_CHAN; ch++) begin
          if (strb.chanIdx == 8'(ch)) rdData[EVT_W-1:0] = maskAll[ch*EVT_W +: EVT_W];
        end
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/hcirq_agg.sv
module hcirq_agg
  import hcirq_pkg::*;
#(
  parameter int NUM_CHAN = 12,
  parameter int EVT_W    = 8,
  parameter int DATA_W   = 16,
  localparam int ADDR_W  = $clog2(2 + 2 * NUM_CHAN)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      regWrEn,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic [NUM_CHAN*EVT_W-1:0] evtPulse,
  output logic                      irqOut
);

  hcirq_strb_t               strb;
  logic [NUM_CHAN*EVT_W-1:0] statusAll;
  logic [NUM_CHAN*EVT_W-1:0] maskAll;
  logic [NUM_CHAN-1:0]       summary;

  hcirq_ctrl #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  hcirq_dp #(.NUM_CHAN(NUM_CHAN), .EVT_W(EVT_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrBits    (regWrData[EVT_W-1:0]),
    .evtPulse  (evtPulse),
    .rdData    (regRdData),
    .coreIrq   (irqOut),
    .statusAll (statusAll),
    .maskAll   (maskAll),
    .summary   (summary)
  );

endmodule

// File: rtl/hcirq_agg_chk.sv
module hcirq_agg_chk #(
  parameter int NUM_CHAN = 12,
  parameter int EVT_W    = 8,
  parameter int ADDR_W   = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         regAddr,
  input logic                      regWrEn,
  input logic [NUM_CHAN*EVT_W-1:0] evtPulse,
  input logic [NUM_CHAN*EVT_W-1:0] statusAll,
  input logic [NUM_CHAN*EVT_W-1:0] maskAll,
  input logic [NUM_CHAN-1:0]       summary,
  input logic                      irqOut
);

  AST_IRQ_KNOWN: assert property (@(posedge clk) disable iff (!rstN) !$isunknown(irqOut)); // R1

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((statusAll & $past(evtPulse)) == $past(evtPulse))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn) |=> ((statusAll & ~$past(statusAll) & ~$past(evtPulse)) == '0)); // R2

  AST_IRQ_FROM_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (summary != '0)); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !regWrEn) |=> irqOut); // R9

  AST_UPPER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr < ADDR_W'(2)) |=>
      ($stable(maskAll) && ((~statusAll & $past(statusAll)) == '0))); // R8

endmodule

bind hcirq_agg hcirq_agg_chk #(.NUM_CHAN(NUM_CHAN), .EVT_W(EVT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .evtPulse  (evtPulse),
  .statusAll (statusAll),
  .maskAll   (maskAll),
  .summary   (summary),
  .irqOut    (irqOut)
);

// File: tb/tb_hcirq_agg.sv
module tb_hcirq_agg;

  localparam int NUM_CHAN = 12;
  localparam int EVT_W    = 8;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = $clog2(2 + 2 * NUM_CHAN);
  localparam int NUM_REGS = 2 + 2 * NUM_CHAN;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic [ADDR_W-1:0]         regAddr = '0;
  logic                      regWrEn = 1'b0;
  logic [DATA_W-1:0]         regWrData = '0;
  logic [DATA_W-1:0]         regRdData;
  logic [NUM_CHAN*EVT_W-1:0] evtPulse = '0;
  logic                      irqOut;

  int checks = 0;
  int fails  = 0;
  logic [EVT_W-1:0] mStat [NUM_CHAN];
  logic [EVT_W-1:0] mMask [NUM_CHAN];

  always #2 clk = ~clk;

  hcirq_agg #(.NUM_CHAN(NUM_CHAN), .EVT_W(EVT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse), .irqOut(irqOut)
  );

  function automatic logic [NUM_CHAN-1:0] expSummary();
    logic [NUM_CHAN-1:0] s;
    for (int c = 0; c < NUM_CHAN; c++) s[c] = |(mStat[c] & mMask[c]);
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] expRead(int a);
    logic [DATA_W-1:0] r;
    r = '0;
    if (a == 0) r[0] = |expSummary();
    else if (a == 1) r[NUM_CHAN-1:0] = expSummary();
    else if (a < NUM_REGS) begin
      if ((a - 2) % 2 == 0) r[EVT_W-1:0] = mStat[(a - 2) / 2];
      else r[EVT_W-1:0] = mMask[(a - 2) / 2];
    end
    return r;
  endfunction

  function automatic void modelStep(logic wr, int a, logic [DATA_W-1:0] d,
                                    logic [NUM_CHAN*EVT_W-1:0] ev);
    for (int c = 0; c < NUM_CHAN; c++) begin
      logic [EVT_W-1:0] clr;
      clr = (wr && a == 2 + 2 * c) ? d[EVT_W-1:0] : '0;
      if (wr && a == 3 + 2 * c) mMask[c] = d[EVT_W-1:0];
      mStat[c] = (mStat[c] & ~clr) | ev[c*EVT_W +: EVT_W];
    end
  endfunction

  task automatic doStep(logic wr, int a, logic [DATA_W-1:0] d, logic [NUM_CHAN*EVT_W-1:0] ev);
    @(negedge clk);
    regWrEn = wr; regAddr = ADDR_W'(a); regWrData = d; evtPulse = ev;
    @(posedge clk);
    modelStep(wr, a, d, ev);
    #1;
    regWrEn = 1'b0; evtPulse = '0;
  endtask

  task automatic readChk(int a, string tag);
    logic [DATA_W-1:0] e;
    @(negedge clk);
    regWrEn = 1'b0; evtPulse = '0; regAddr = ADDR_W'(a);
    #1;
    e = expRead(a);
    checks++;
    if (regRdData !== e) begin
      fails++;
      $display("FAIL %s addr %0d: read 0x%0h expected 0x%0h", tag, a, regRdData, e);
    end
    checks++;
    if (irqOut !== (|expSummary())) begin
      fails++;
      $display("FAIL %s irqOut: got %b expected %b", tag, irqOut, |expSummary());
    end
  endtask

  function automatic logic [NUM_CHAN*EVT_W-1:0] oneEvt(int c, int b);
    logic [NUM_CHAN*EVT_W-1:0] v;
    v = '0;
    v[c*EVT_W + b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    for (int c = 0; c < NUM_CHAN; c++) begin mStat[c] = '0; mMask[c] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readChk(0, "R1"); readChk(1, "R1"); readChk(2, "R1"); readChk(3, "R1");
    readChk(NUM_REGS - 1, "R1");

    // R2 masked event still latched, no interrupt
    doStep(1'b0, 0, '0, oneEvt(2, 1));
    readChk(6, "R2"); readChk(1, "R5");

    // R7 enabling a pending bit raises summary and irq
    doStep(1'b1, 7, 16'h0002, '0);
    readChk(7, "R7"); readChk(1, "R7"); readChk(0, "R6");

    // R8 writes to upper levels ignored
    doStep(1'b1, 1, 16'hffff, '0);
    doStep(1'b1, 0, 16'hffff, '0);
    readChk(1, "R8"); readChk(6, "R8"); readChk(7, "R8");

    // R10 mask write on ch4 leaves its status and ch2 alone
    doStep(1'b0, 0, '0, oneEvt(4, 0));
    doStep(1'b1, 11, 16'h0001, '0);
    readChk(10, "R10"); readChk(6, "R10"); readChk(1, "R5");

    // R3 zero write keeps bits; R9 irq holds while ch4 pending
    doStep(1'b1, 6, 16'h0000, '0);
    readChk(6, "R3");
    doStep(1'b1, 6, 16'h0002, '0);
    readChk(6, "R3"); readChk(0, "R9");
    doStep(1'b1, 10, 16'h0001, '0);
    readChk(0, "R9"); readChk(1, "R9");

    // R4 clear and event on the same bit
    doStep(1'b0, 0, '0, oneEvt(3, 0));
    doStep(1'b1, 8, 16'h0001, oneEvt(3, 0));
    readChk(8, "R4");

    // R11 unmapped addresses
    doStep(1'b1, NUM_REGS, 16'h00ff, '0);
    readChk(NUM_REGS, "R11"); readChk((1 << ADDR_W) - 1, "R11"); readChk(8, "R11");

    // Random mix; collisions of clear and event occur naturally
    seed = $urandom(32'h5eed1234);
    for (int i = 0; i < 600; i++) begin
      logic [NUM_CHAN*EVT_W-1:0] ev;
      int a;
      ev = '0;
      if ($urandom_range(3, 0) == 0) ev = oneEvt($urandom_range(NUM_CHAN - 1, 0), $urandom_range(EVT_W - 1, 0));
      a = $urandom_range((1 << ADDR_W) - 1, 0);
      doStep($urandom_range(1, 0) == 1, a, DATA_W'($urandom()), ev);
      readChk($urandom_range((1 << ADDR_W) - 1, 0), "R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule